// File: doc/BRIEF.md
# Microcoded Shift Datapath Slice

This block is an 8-bit datapath slice whose behaviour is chosen on every clock by a 3-bit control-store address. The address indexes a table of eight operation words, which are set by parameters. Each word picks three things: the ALU function, the shift operation, and the source that writes the accumulator. Alongside the table sit static settings. These cover the default shift-in bit, the shift-in source for each of two selectable sets, the static carry-in for each set, whether the serial output taps the LSB or the MSB, and whether the FIFO status flags are registered.

A host bus pushes bytes into a small FIFO. The default table sets the slice up as a UART transmit serializer. Word 0 moves the oldest FIFO byte into the accumulator. Word 1 passes the accumulator through the ALU, shifts it right by one, and writes it back. The serial output then presents the byte LSB-first. Baud timing, framing and the state machine that sequences the addresses belong to the surrounding logic.

Top module: `shift_dp_slice`

## Requirements
- R1: While rst_ni is low, acc_o is 0x00, so_o is 0, fifo_empty_o is 1 and fifo_not_full_o is 1.
- R2: A host write is stored only when the FIFO holds fewer than 4 entries. A write made while 4 entries are held is dropped, even if the same cycle pops.
- R3: With cs_addr_i = 0 (load word) and the FIFO not empty, acc_o takes the oldest stored byte after the clock edge, and that entry is removed. Bytes come out in the order they were written.
- R4: With cs_addr_i = 0 and the FIFO empty, acc_o keeps its value and nothing is removed.
- R5: With cs_addr_i = 1 (shift word) and the default shift-in bit 0, acc_o becomes {0, acc_o[7:1]}. Eight such cycles leave 0x00.
- R6: With the LSB tap, so_o equals acc_o[0] in every cycle, whether or not a shift runs. A loaded byte followed by eight shift cycles therefore appears LSB-first.
- R7: Addresses 2 to 7 of the default table write nothing. acc_o is unchanged and the FIFO is not popped.
- R8: With registered status (the default), fifo_empty_o and fifo_not_full_o show the fill level as it stood one clock earlier, through exactly one flop.
- R9: With the MSB tap, so_o equals acc_o[7]. A left shift using a default shift-in bit of 1 gives {acc_o[6:0], 1}.
- R10: A word selecting add-with-carry through carry set B, with static carry 1, increments acc_o, and 0xFF wraps to 0x00.
- R11: With unregistered status, the flags follow the current fill level in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Datapath clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_addr_i | input | 3 | Control-store address that selects this cycle's operation word |
| host_wr_i | input | 1 | Host write strobe for the FIFO |
| host_data_i | input | 8 | Host write data |
| si_i | input | 1 | External shift-in bit, used when a set selects the external source |
| so_o | output | 1 | Serial output, the tapped LSB or MSB of the accumulator |
| acc_o | output | 8 | Accumulator value |
| fifo_empty_o | output | 1 | FIFO empty flag |
| fifo_not_full_o | output | 1 | FIFO not-full flag |

## Verification
The assertions assume that cs_addr_i and the host strobes are steady around the rising edge, and that rst_ni is released away from an edge. The load and hold properties also assume that the configured table uses only the write sources defined in the package. The stimulus changes every input one nanosecond after an edge. It walks all eight addresses with both tables. It drives writes into a full FIFO and loads from an empty one on purpose, so that the drop and hold rules are exercised rather than avoided.

// File: rtl/shift_dp_pkg.sv
package shift_dp_pkg;

  typedef enum logic [1:0] {
    ALU_PASS   = 2'd0,
    ALU_ADD_CI = 2'd1,
    ALU_SUB_CI = 2'd2,
    ALU_NOT    = 2'd3
  } alu_fn_e;

  typedef enum logic [1:0] {
    SH_NONE  = 2'd0,
    SH_RIGHT = 2'd1,
    SH_LEFT  = 2'd2,
    SH_SWAP  = 2'd3
  } shift_e;

  typedef enum logic [1:0] {
    WR_NONE = 2'd0,
    WR_ALU  = 2'd1,
    WR_FIFO = 2'd2
  } wr_src_e;

  typedef enum logic [1:0] {
    SI_DEFAULT = 2'd0,
    SI_EXT     = 2'd1,
    SI_ROTATE  = 2'd2
  } si_src_e;

  typedef struct packed {
    alu_fn_e alu;
    shift_e  shift;
    wr_src_e wr_src;
    logic    ci_sel;   // 0: carry set A, 1: set B
    logic    si_sel;   // 0: shift-in set A, 1: set B
  } op_word_t;

  localparam op_word_t OP_NOP = '{alu: ALU_PASS, shift: SH_NONE, wr_src: WR_NONE,
                                   ci_sel: 1'b0, si_sel: 1'b0};
  localparam op_word_t OP_LOAD = '{alu: ALU_PASS, shift: SH_NONE, wr_src: WR_FIFO,
                                    ci_sel: 1'b0, si_sel: 1'b0};
  localparam op_word_t OP_SHR = '{alu: ALU_PASS, shift: SH_RIGHT, wr_src: WR_ALU,
                                   ci_sel: 1'b0, si_sel: 1'b0};

  localparam op_word_t [7:0] UART_TX_OPS = {OP_NOP, OP_NOP, OP_NOP, OP_NOP,
                                            OP_NOP, OP_NOP, OP_SHR, OP_LOAD};

endpackage

// File: rtl/dp_host_fifo.sv
module dp_host_fifo #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DEPTH  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              pop_i,
  output logic [DATA_W-1:0] head_o,
  output logic              empty_o,
  output logic              full_o
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);
  localparam logic [AW-1:0] LAST_C  = AW'(DEPTH - 1);

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [AW-1:0]     rd_q, wr_q;
  logic [CW-1:0]     cnt_q;
  logic              do_push, do_pop;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == LAST_C) ? '0 : p + AW'(1);
  endfunction

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == DEPTH_C);
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign head_o  = mem_q[rd_q];

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_q] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wr_q <= nxt(wr_q);
      if (do_pop)  rd_q <= nxt(rd_q);
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + CW'(1);
        2'b01:   cnt_q <= cnt_q - CW'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  a_r2_count_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= DEPTH_C);

  a_r2_full_push_dropped: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && push_i && !pop_i) |=> full_o && $stable(wr_q));

  a_r3_pop_advances: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !empty_o) |=> rd_q != $past(rd_q) || DEPTH == 1);

endmodule

// File: rtl/dp_alu_shift.sv
module dp_alu_shift
  import shift_dp_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic              ci_i,
  input  alu_fn_e           fn_i,
  input  shift_e            shift_i,
  input  logic              si_ext_i,
  input  logic              si_rot_i,
  output logic [DATA_W-1:0] res_o
);
  localparam int unsigned HALF = DATA_W / 2;

  logic [DATA_W-1:0] alu;
  logic              si_bit;

  always_comb begin
    unique case (fn_i)
      ALU_PASS:   alu = a_i;
      ALU_ADD_CI: alu = a_i + DATA_W'(ci_i);
      ALU_SUB_CI: alu = a_i - DATA_W'(ci_i);
      default:    alu = ~a_i;
    endcase
  end

  // rotate feeds back the bit leaving on the far side
  assign si_bit = si_rot_i ? ((shift_i == SH_LEFT) ? alu[DATA_W-1] : alu[0]) : si_ext_i;

  always_comb begin
    unique case (shift_i)
      SH_NONE:  res_o = alu;
      SH_RIGHT: res_o = {si_bit, alu[DATA_W-1:1]};
      SH_LEFT:  res_o = {alu[DATA_W-2:0], si_bit};
      default:  res_o = {alu[HALF-1:0], alu[DATA_W-1:HALF]};
    endcase
  end

endmodule

// File: rtl/shift_dp_slice.sv
module shift_dp_slice
  import shift_dp_pkg::*;
#(
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned FIFO_DEPTH = 4,
  parameter int unsigned CS_W       = 3,
  parameter op_word_t [(2**CS_W)-1:0] OPS = UART_TX_OPS,
  parameter logic    DEF_SI     = 1'b0,
  parameter si_src_e SI_SRC_A   = SI_DEFAULT,
  parameter si_src_e SI_SRC_B   = SI_EXT,
  parameter logic    CI_A       = 1'b0,
  parameter logic    CI_B       = 1'b1,
  parameter logic    SO_MSB     = 1'b0,
  parameter logic    FIFO_ASYNC = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CS_W-1:0]   cs_addr_i,
  input  logic              host_wr_i,
  input  logic [DATA_W-1:0] host_data_i,
  input  logic              si_i,
  output logic              so_o,
  output logic [DATA_W-1:0] acc_o,
  output logic              fifo_empty_o,
  output logic              fifo_not_full_o
);
  op_word_t          op;
  si_src_e           si_src;
  logic              si_ext, si_rot, ci;
  logic [DATA_W-1:0] acc_q, alu_res, fifo_head;
  logic              fifo_empty, fifo_full, pop;

  assign op     = OPS[cs_addr_i];
  assign si_src = op.si_sel ? SI_SRC_B : SI_SRC_A;
  assign si_ext = (si_src == SI_EXT) ? si_i : DEF_SI;
  assign si_rot = (si_src == SI_ROTATE);
  assign ci     = op.ci_sel ? CI_B : CI_A;
  assign pop    = (op.wr_src == WR_FIFO);

  dp_host_fifo #(.DATA_W(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .push_i (host_wr_i),
    .data_i (host_data_i),
    .pop_i  (pop),
    .head_o (fifo_head),
    .empty_o(fifo_empty),
    .full_o (fifo_full)
  );

  dp_alu_shift #(.DATA_W(DATA_W)) u_alu (
    .a_i     (acc_q),
    .ci_i    (ci),
    .fn_i    (op.alu),
    .shift_i (op.shift),
    .si_ext_i(si_ext),
    .si_rot_i(si_rot),
    .res_o   (alu_res)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
    end else begin
      unique case (op.wr_src)
        WR_ALU:  acc_q <= alu_res;
        WR_FIFO: if (!fifo_empty) acc_q <= fifo_head;
        default: acc_q <= acc_q;
      endcase
    end
  end

  assign acc_o = acc_q;
  assign so_o  = SO_MSB ? acc_q[DATA_W-1] : acc_q[0];

  generate
    if (FIFO_ASYNC) begin : g_status_sync
      logic empty_q, not_full_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          empty_q    <= 1'b1;
          not_full_q <= 1'b1;
        end else begin
          empty_q    <= fifo_empty;
          not_full_q <= !fifo_full;
        end
      end
      assign fifo_empty_o    = empty_q;
      assign fifo_not_full_o = not_full_q;

      a_r8_status_lag: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fifo_empty_o == $past(fifo_empty) && fifo_not_full_o == !$past(fifo_full));
    end else begin : g_status_direct
      assign fifo_empty_o    = fifo_empty;
      assign fifo_not_full_o = !fifo_full;
    end
  endgenerate

  a_r3_load_takes_head: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op.wr_src == WR_FIFO && !fifo_empty) |=> acc_q == $past(fifo_head));

  a_r4_empty_load_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op.wr_src == WR_FIFO && fifo_empty) |=> $stable(acc_q));

  a_r7_idle_word_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op.wr_src == WR_NONE) |=> $stable(acc_q));

  a_r5_shift_in_fill: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op.wr_src == WR_ALU && op.shift == SH_RIGHT && op.alu == ALU_PASS && !si_rot)
      |=> acc_q == {$past(si_ext), $past(acc_q[DATA_W-1:1])});

endmodule

// File: tb/shift_dp_slice_tb.sv
`timescale 1ns/1ps
module shift_dp_slice_tb;
  import shift_dp_pkg::*;

  localparam int WD_CYC = 200000;

  localparam op_word_t OP_SHL = '{alu: ALU_PASS, shift: SH_LEFT, wr_src: WR_ALU,
                                   ci_sel: 1'b0, si_sel: 1'b0};
  localparam op_word_t OP_INC = '{alu: ALU_ADD_CI, shift: SH_NONE, wr_src: WR_ALU,
                                   ci_sel: 1'b1, si_sel: 1'b0};
  localparam op_word_t [7:0] OPS_ALT = {OP_NOP, OP_NOP, OP_NOP, OP_NOP,
                                        OP_NOP, OP_INC, OP_SHL, OP_LOAD};

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] cs_addr = '0;
  logic       host_wr = 1'b0;
  logic [7:0] host_data = '0;
  logic       so_m, so_a, emp_m, emp_a, nf_m, nf_a;
  logic [7:0] acc_m, acc_a;

  int n_chk = 0;
  int n_err = 0;

  logic [7:0] q[$];
  logic [7:0] m_acc = '0, a_acc = '0;

  always #2 clk = ~clk;

  shift_dp_slice u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cs_addr_i(cs_addr), .host_wr_i(host_wr),
    .host_data_i(host_data), .si_i(1'b0), .so_o(so_m), .acc_o(acc_m),
    .fifo_empty_o(emp_m), .fifo_not_full_o(nf_m)
  );

  shift_dp_slice #(
    .OPS(OPS_ALT), .DEF_SI(1'b1), .SO_MSB(1'b1), .FIFO_ASYNC(1'b0)
  ) u_dut_alt (
    .clk_i(clk), .rst_ni(rst_n), .cs_addr_i(cs_addr), .host_wr_i(host_wr),
    .host_data_i(host_data), .si_i(1'b0), .so_o(so_a), .acc_o(acc_a),
    .fifo_empty_o(emp_a), .fifo_not_full_o(nf_a)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  // one clock: drive, model the edge, compare 1 ns after it
  task automatic cyc(input logic [2:0] addr, input logic wr, input logic [7:0] data);
    int         sz;
    logic [7:0] head;
    string      tm, ta;
    cs_addr   = addr;
    host_wr   = wr;
    host_data = data;
    sz   = q.size();
    head = (sz > 0) ? q[0] : 8'h00;
    tm = (addr == 0) ? ((sz > 0) ? "R3" : "R4") : (addr == 1) ? "R5" : "R7";
    ta = (addr == 0) ? ((sz > 0) ? "R3" : "R4") : (addr == 1) ? "R9" :
         (addr == 2) ? "R10" : "R7";
    case (addr)
      3'd0: begin
        if (sz > 0) begin m_acc = head; a_acc = head; end
      end
      3'd1: begin m_acc = {1'b0, m_acc[7:1]}; a_acc = {a_acc[6:0], 1'b1}; end
      3'd2: a_acc = a_acc + 8'd1;
      default: ;
    endcase
    if (addr == 0 && sz > 0) void'(q.pop_front());
    if (wr && sz < 4) q.push_back(data);
    @(posedge clk);
    #1;
    chk(tm, acc_m, m_acc);
    chk("R6", {7'd0, so_m}, {7'd0, m_acc[0]});
    chk("R8", {6'd0, emp_m, nf_m}, {6'd0, sz == 0, sz < 4});
    chk(ta, acc_a, a_acc);
    chk("R9", {7'd0, so_a}, {7'd0, a_acc[7]});
    chk("R11", {6'd0, emp_a, nf_a}, {6'd0, q.size() == 0, q.size() < 4});
  endtask

  initial begin
    #(WD_CYC * 4);
    n_err++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [7:0] sent;
    logic [7:0] got;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk("R1", acc_m, 8'h00);
    chk("R1", {7'd0, so_m}, 8'h00);
    chk("R1", {6'd0, emp_m, nf_m}, 8'h03);
    chk("R1", acc_a, 8'h00);
    rst_n = 1'b1;

    // R6 serialize a byte LSB-first, R5 ends at zero
    sent = 8'hA5;
    cyc(3'd3, 1'b1, sent);
    cyc(3'd0, 1'b0, 8'h00);
    for (int i = 0; i < 8; i++) begin
      got[i] = so_m;
      cyc(3'd1, 1'b0, 8'h00);
    end
    chk("R6", got, sent);
    chk("R5", acc_m, 8'h00);

    // R2 overflow drop, R3 order, R4 empty load
    for (int i = 0; i < 5; i++) cyc(3'd4, 1'b1, 8'h11 * (i + 1));
    for (int i = 0; i < 4; i++) begin
      cyc(3'd0, 1'b0, 8'h00);
      chk("R2", acc_m, 8'h11 * (i + 1));
    end
    cyc(3'd0, 1'b0, 8'h00);
    chk("R4", acc_m, 8'h44);

    // R10 increment wrap on alt, R7 idle word on default table
    cyc(3'd5, 1'b1, 8'hFF);
    cyc(3'd0, 1'b0, 8'h00);
    cyc(3'd2, 1'b0, 8'h00);
    chk("R10", acc_a, 8'h00);
    chk("R7", acc_m, 8'hFF);

    // R9 left shift fills ones on alt
    for (int i = 0; i < 8; i++) cyc(3'd1, 1'b0, 8'h00);
    chk("R9", acc_a, 8'hFF);

    // mixed traffic over all addresses
    for (int i = 0; i < 400; i++) begin
      cyc(3'((i * 5 + i / 7) % 8), (i % 3) != 0, 8'((i * 37 + 11) & 8'hFF));
    end

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule